// File: doc/BRIEF.md
# Keyboard/Auxiliary Controller Host Port

This block is the processor-facing half of a PS/2 style keyboard controller. The host sees two byte-wide ports. The data port (`bus_sel_cmd`=0) returns queued reply bytes when read and accepts data bytes when written. The command/status port (`bus_sel_cmd`=1) returns the status byte when read and accepts controller commands when written. The block keeps two reply queues, one for the keyboard and one for the auxiliary (pointing) device. It also holds a mode byte and a status byte, and it raises one interrupt level for each queue.

A controller command can do one of four things: answer at once through the keyboard queue, change a mode bit, move the address-line-20 gate, or ask for a system reset. Some commands instead arm a pending destination, and the next data-port write then goes to that destination. When no destination is pending, a data-port write is meant for the keyboard itself. It is passed out for one cycle on a byte-push interface, toward a separate keyboard responder.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x0C and the mode byte (reported by command 0x20) is 0x03. Both queues are empty, both interrupts are low, the A20 gate is low, the reset request is low and the forward strobe is low.
- R2: Every byte that enters either queue sets status bit 0 (any output byte present). A byte that enters the auxiliary queue also sets status bit 5 (auxiliary byte present).
- R3: A data-port read takes the oldest auxiliary byte if there is one, otherwise the oldest keyboard byte. It returns 0x00 when both queues are empty. A status read removes nothing. A read strobe given together with a write strobe is ignored.
- R4: After a data-port read, bit 5 clears only if the auxiliary queue is now empty. Bit 0 clears only if both queues are now empty.
- R5: The keyboard interrupt equals status bit 0 AND mode bit 0. The auxiliary interrupt equals status bit 5 AND mode bit 1.
- R6: Some commands queue a reply byte. 0x20 queues the mode byte. 0xAA sets status bit 2 and queues 0x55. 0xA9, 0xAB and 0xC0 each queue 0x00.
- R7: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. 0xDD raises the A20 gate and 0xDF lowers it.
- R8: 0xD0 queues the output-port byte. Bit 0 is always 1, bit 1 is the A20 gate, and bits 4 and 5 are status bits 0 and 5 as they stood before the command. All other bits are 0.
- R9: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a destination for the next data-port write: the mode byte, the output port, the keyboard queue, the auxiliary queue, or nowhere (0xD4 drops the byte). That write disarms the destination.
- R10: A write to the output port sets the A20 gate from data bit 1. If data bit 0 is 0, it also pulses the reset request.
- R11: Command 0xFE pulses the reset request. Each reset request lasts exactly one cycle.
- R12: Each queue holds 64 bytes in arrival order. A byte sent to a full queue is dropped and the bytes already stored are unchanged.
- R13: A data-port write with no armed destination raises `kbd_tx_valid` for one cycle with the byte on `kbd_tx_byte`, in the cycle after the write. Nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_sel_cmd | input | 1 | 0 selects the data port, 1 selects the command/status port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational; on a data read this is the byte removed at the clock edge) |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| a20_gate | output | 1 | Address-line-20 gate |
| sys_reset_req | output | 1 | One-cycle system reset request |
| kbd_tx_valid | output | 1 | One-cycle strobe: byte for the keyboard responder |
| kbd_tx_byte | output | 8 | Byte for the keyboard responder |

## Verification
The hardest state to reach from the ports is a full queue that is then pushed again. Reaching it takes 64 writes of an armed keyboard-queue command and its data byte, and a further six such pairs must be seen to vanish. The bench loops over 70 such pairs with the byte values counting up. It then drains the queue and expects exactly 0 to 63 in order, followed by the empty value. A second hard case is a read that leaves the auxiliary queue empty while keyboard bytes remain. This needs both queues filled in a known order through the 0xD2/0xD3 commands before the status byte is examined between reads.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam logic [7:0] CMD_RD_MODE   = 8'h20;
  localparam logic [7:0] CMD_WR_MODE   = 8'h60;
  localparam logic [7:0] CMD_AUX_OFF   = 8'hA7;
  localparam logic [7:0] CMD_AUX_ON    = 8'hA8;
  localparam logic [7:0] CMD_AUX_TEST  = 8'hA9;
  localparam logic [7:0] CMD_SELFTEST  = 8'hAA;
  localparam logic [7:0] CMD_KBD_TEST  = 8'hAB;
  localparam logic [7:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [7:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [7:0] CMD_RD_INPUT  = 8'hC0;
  localparam logic [7:0] CMD_RD_OUTP   = 8'hD0;
  localparam logic [7:0] CMD_WR_OUTP   = 8'hD1;
  localparam logic [7:0] CMD_WR_KBUF   = 8'hD2;
  localparam logic [7:0] CMD_WR_ABUF   = 8'hD3;
  localparam logic [7:0] CMD_WR_AUXDEV = 8'hD4;
  localparam logic [7:0] CMD_GATE_ON   = 8'hDD;
  localparam logic [7:0] CMD_GATE_OFF  = 8'hDF;
  localparam logic [7:0] CMD_SYSRST    = 8'hFE;

  localparam logic [7:0] MODE_RESET    = 8'h03;
  localparam logic [7:0] SELFTEST_BYTE = 8'h55;
  localparam int MD_KIRQ = 0;
  localparam int MD_AIRQ = 1;
  localparam int MD_KOFF = 4;
  localparam int MD_AOFF = 5;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTP, PEND_KBUF, PEND_ABUF, PEND_AUXDEV
  } pend_e;

  typedef enum logic [1:0] {
    RSP_MODE, RSP_PASS, RSP_ZERO, RSP_OUTP
  } rsp_e;

  typedef struct packed {
    logic       rsp_en;
    rsp_e       rsp_sel;
    logic       latch;
    pend_e      pend;
    logic [7:0] mode_set;
    logic [7:0] mode_clr;
    logic       gate_on;
    logic       gate_off;
    logic       sysrst;
    logic       selftest;
  } cmd_act_t;

  function automatic logic [7:0] outport_byte(input logic gate, input logic obf,
                                              input logic auxf);
    return {2'b00, auxf, obf, 2'b00, gate, 1'b1};
  endfunction

  function automatic logic [7:0] status_byte(input logic obf, input logic auxf,
                                             input logic selftest);
    return {2'b00, auxf, 1'b0, 1'b1, selftest, 1'b0, obf};
  endfunction

  function automatic logic irq_level(input logic flag, input logic enable);
    return flag & enable;
  endfunction

endpackage

// File: rtl/kbc_byte_fifo.sv
module kbc_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wrap_inc(wp);
      if (pop_ok)  rp <= wrap_inc(rp);
      level <= level + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  a_r12_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (level == $past(level)));
  a_r3_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_act_t   act
);
  always_comb begin
    act          = '0;
    act.rsp_sel  = RSP_ZERO;
    act.pend     = PEND_NONE;
    unique case (cmd_byte)
      CMD_RD_MODE:   begin act.rsp_en = 1'b1; act.rsp_sel = RSP_MODE; end
      CMD_SELFTEST:  begin act.rsp_en = 1'b1; act.rsp_sel = RSP_PASS; act.selftest = 1'b1; end
      CMD_AUX_TEST,
      CMD_KBD_TEST,
      CMD_RD_INPUT:  begin act.rsp_en = 1'b1; act.rsp_sel = RSP_ZERO; end
      CMD_RD_OUTP:   begin act.rsp_en = 1'b1; act.rsp_sel = RSP_OUTP; end
      CMD_AUX_OFF:   act.mode_set[MD_AOFF] = 1'b1;
      CMD_AUX_ON:    act.mode_clr[MD_AOFF] = 1'b1;
      CMD_KBD_OFF:   act.mode_set[MD_KOFF] = 1'b1;
      CMD_KBD_ON:    act.mode_clr[MD_KOFF] = 1'b1;
      CMD_GATE_ON:   act.gate_on  = 1'b1;
      CMD_GATE_OFF:  act.gate_off = 1'b1;
      CMD_SYSRST:    act.sysrst   = 1'b1;
      CMD_WR_MODE:   begin act.latch = 1'b1; act.pend = PEND_MODE;   end
      CMD_WR_OUTP:   begin act.latch = 1'b1; act.pend = PEND_OUTP;   end
      CMD_WR_KBUF:   begin act.latch = 1'b1; act.pend = PEND_KBUF;   end
      CMD_WR_ABUF:   begin act.latch = 1'b1; act.pend = PEND_ABUF;   end
      CMD_WR_AUXDEV: begin act.latch = 1'b1; act.pend = PEND_AUXDEV; end
      default: ;
    endcase
  end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
  import kbc_pkg::*;
(
  input  pend_e pend,
  input  logic  wr_data,
  output logic  mode_wr,
  output logic  outp_wr,
  output logic  kbuf_push,
  output logic  abuf_push,
  output logic  fwd
);
  always_comb begin
    mode_wr   = 1'b0;
    outp_wr   = 1'b0;
    kbuf_push = 1'b0;
    abuf_push = 1'b0;
    fwd       = 1'b0;
    if (wr_data) begin
      unique case (pend)
        PEND_NONE:   fwd       = 1'b1;
        PEND_MODE:   mode_wr   = 1'b1;
        PEND_OUTP:   outp_wr   = 1'b1;
        PEND_KBUF:   kbuf_push = 1'b1;
        PEND_ABUF:   abuf_push = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int QDEPTH = 64,
  localparam int AW    = $clog2(QDEPTH),
  localparam int NQ    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel_cmd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_kbd,
  output logic       irq_aux,
  output logic       a20_gate,
  output logic       sys_reset_req,
  output logic       kbd_tx_valid,
  output logic [7:0] kbd_tx_byte
);
  localparam int QK = 0;
  localparam int QA = 1;

  logic       wr_cmd, wr_dat, rd_dat;
  cmd_act_t   act;
  logic       mode_wr, outp_wr, kbuf_push, abuf_push, fwd;
  pend_e      pend_r;
  logic [7:0] mode_r;
  logic       obf_r, auxf_r, selftest_r;
  logic [7:0] rsp_byte;

  logic          q_push  [NQ];
  logic [7:0]    q_din   [NQ];
  logic          q_pop   [NQ];
  logic [7:0]    q_head  [NQ];
  logic          q_empty [NQ];
  logic          q_full  [NQ];
  logic [AW:0]   q_level [NQ];

  assign wr_cmd = bus_wr & bus_sel_cmd;
  assign wr_dat = bus_wr & ~bus_sel_cmd;
  assign rd_dat = bus_rd & ~bus_wr & ~bus_sel_cmd;

  kbc_cmd_decode u_dec (.cmd_byte(bus_wdata), .act(act));

  kbc_data_route u_route (
    .pend(pend_r), .wr_data(wr_dat), .mode_wr(mode_wr), .outp_wr(outp_wr),
    .kbuf_push(kbuf_push), .abuf_push(abuf_push), .fwd(fwd)
  );

  always_comb begin
    unique case (act.rsp_sel)
      RSP_MODE: rsp_byte = mode_r;
      RSP_PASS: rsp_byte = SELFTEST_BYTE;
      RSP_OUTP: rsp_byte = outport_byte(a20_gate, obf_r, auxf_r);
      default:  rsp_byte = 8'h00;
    endcase
  end

  // queue feeds and pops; the aux queue has read priority
  assign q_push[QK] = (wr_cmd & act.rsp_en) | kbuf_push;
  assign q_din[QK]  = wr_cmd ? rsp_byte : bus_wdata;
  assign q_push[QA] = abuf_push;
  assign q_din[QA]  = bus_wdata;
  assign q_pop[QA]  = rd_dat & ~q_empty[QA];
  assign q_pop[QK]  = rd_dat & q_empty[QA] & ~q_empty[QK];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    kbc_byte_fifo #(.DEPTH(QDEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push[g]), .din(q_din[g]),
      .pop(q_pop[g]), .dout(q_head[g]), .empty(q_empty[g]),
      .full(q_full[g]), .level(q_level[g])
    );
  end

  // occupancy left after this read
  logic aux_left_empty, kbd_left_empty;
  assign aux_left_empty = q_empty[QA] | (q_pop[QA] & (q_level[QA] == (AW+1)'(1)));
  assign kbd_left_empty = q_empty[QK] | (q_pop[QK] & (q_level[QK] == (AW+1)'(1)));

  always_comb begin
    if (bus_sel_cmd)       bus_rdata = status_byte(obf_r, auxf_r, selftest_r);
    else if (!q_empty[QA]) bus_rdata = q_head[QA];
    else if (!q_empty[QK]) bus_rdata = q_head[QK];
    else                   bus_rdata = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf_r         <= 1'b0;
      auxf_r        <= 1'b0;
      selftest_r    <= 1'b1;
      mode_r        <= MODE_RESET;
      pend_r        <= PEND_NONE;
      a20_gate      <= 1'b0;
      sys_reset_req <= 1'b0;
      kbd_tx_valid  <= 1'b0;
      kbd_tx_byte   <= 8'h00;
    end else begin
      if (q_push[QK] | q_push[QA]) obf_r <= 1'b1;
      if (q_push[QA]) auxf_r <= 1'b1;
      else if (rd_dat && aux_left_empty) begin
        auxf_r <= 1'b0;
        if (kbd_left_empty) obf_r <= 1'b0;
      end

      if (wr_cmd && act.selftest) selftest_r <= 1'b1;

      if (wr_cmd)       mode_r <= (mode_r | act.mode_set) & ~act.mode_clr;
      else if (mode_wr) mode_r <= bus_wdata;

      if (wr_cmd && act.latch) pend_r <= act.pend;
      else if (wr_dat)         pend_r <= PEND_NONE;

      if (wr_cmd && act.gate_on)       a20_gate <= 1'b1;
      else if (wr_cmd && act.gate_off) a20_gate <= 1'b0;
      else if (outp_wr)                a20_gate <= bus_wdata[1];

      sys_reset_req <= (wr_cmd & act.sysrst) | (outp_wr & ~bus_wdata[0]);

      kbd_tx_valid <= fwd;
      if (fwd) kbd_tx_byte <= bus_wdata;
    end
  end

  assign irq_kbd = irq_level(obf_r, mode_r[MD_KIRQ]);
  assign irq_aux = irq_level(auxf_r, mode_r[MD_AIRQ]);

  a_r4_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    obf_r == (!q_empty[QK] || !q_empty[QA]));
  a_r4_aux_flag: assert property (@(posedge clk) disable iff (!rst_n)
    auxf_r == !q_empty[QA]);
  a_r5_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_kbd || irq_aux) |-> !(q_empty[QK] && q_empty[QA]));
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (pend_r == PEND_NONE));
  a_r11_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(bus_wr));
  a_r13_tx_src: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_tx_valid |-> $past(wr_dat && pend_r == PEND_NONE));
endmodule

// File: tb/sim_kbc_host_if.sv
module sim_kbc_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_cmd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, kbd_tx_byte;
  logic irq_kbd, irq_aux, a20_gate, sys_reset_req, kbd_tx_valid;
  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  kbc_host_if u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_cmd(bus_sel_cmd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux), .a20_gate(a20_gate),
    .sys_reset_req(sys_reset_req), .kbd_tx_valid(kbd_tx_valid),
    .kbd_tx_byte(kbd_tx_byte)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_cmd = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel_cmd = sel;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // {is_read, sel_cmd, data, expected, requirement}
  localparam int NV = 35;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b1,8'hAA,8'h00,4'd6}, {1'b1,1'b0,8'h00,8'h55,4'd6},   // R6 self test
    {1'b0,1'b1,8'h20,8'h00,4'd6}, {1'b1,1'b0,8'h00,8'h03,4'd6},   // R6 mode
    {1'b0,1'b1,8'hA9,8'h00,4'd6}, {1'b1,1'b0,8'h00,8'h00,4'd6},
    {1'b0,1'b1,8'hAB,8'h00,4'd6}, {1'b1,1'b0,8'h00,8'h00,4'd6},
    {1'b0,1'b1,8'hC0,8'h00,4'd6}, {1'b1,1'b0,8'h00,8'h00,4'd6},
    {1'b0,1'b1,8'h60,8'h00,4'd9}, {1'b0,1'b0,8'h41,8'h00,4'd9},   // R9 mode write
    {1'b0,1'b1,8'h20,8'h00,4'd9}, {1'b1,1'b0,8'h00,8'h41,4'd9},
    {1'b0,1'b1,8'h60,8'h00,4'd9}, {1'b0,1'b0,8'h03,8'h00,4'd9},
    {1'b0,1'b1,8'hA7,8'h00,4'd7}, {1'b0,1'b1,8'hAD,8'h00,4'd7},   // R7 set bits
    {1'b0,1'b1,8'h20,8'h00,4'd7}, {1'b1,1'b0,8'h00,8'h33,4'd7},
    {1'b0,1'b1,8'hA8,8'h00,4'd7}, {1'b0,1'b1,8'hAE,8'h00,4'd7},   // R7 clear bits
    {1'b0,1'b1,8'h20,8'h00,4'd7}, {1'b1,1'b0,8'h00,8'h03,4'd7},
    {1'b0,1'b1,8'hD2,8'h00,4'd9}, {1'b0,1'b0,8'h9C,8'h00,4'd9},   // R9 keyboard queue
    {1'b1,1'b0,8'h00,8'h9C,4'd9},
    {1'b0,1'b1,8'hD3,8'h00,4'd9}, {1'b0,1'b0,8'h7E,8'h00,4'd9},   // R9 aux queue
    {1'b1,1'b0,8'h00,8'h7E,4'd9},
    {1'b0,1'b1,8'hD4,8'h00,4'd9}, {1'b0,1'b0,8'h11,8'h00,4'd9},   // R9 dropped byte
    {1'b1,1'b0,8'h00,8'h00,4'd9},
    {1'b0,1'b1,8'hDD,8'h00,4'd8}, {1'b0,1'b1,8'hD0,8'h00,4'd8}    // R8 gate up
  };

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b1, v); chk("R1 status", v, 8'h0C);
    chk("R1 irqs", {6'd0, irq_kbd, irq_aux}, 8'h00);
    chk("R1 gate/rst/tx", {5'd0, a20_gate, sys_reset_req, kbd_tx_valid}, 8'h00);
    rd(1'b0, v); chk("R3 empty read", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        rd(VEC[i][20], v);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end else begin
        wr(VEC[i][20], VEC[i][19:12]);
      end
    end
    // R8 output-port byte with gate up, queues empty before command
    rd(1'b0, v); chk("R8 outport gate up", v, 8'h03);
    chk("R7 gate on", {7'd0, a20_gate}, 8'h01);
    wr(1'b1, 8'hDF); chk("R7 gate off", {7'd0, a20_gate}, 8'h00);
    wr(1'b1, 8'hD2); wr(1'b0, 8'hEE);
    wr(1'b1, 8'hD3); wr(1'b0, 8'hEF);
    wr(1'b1, 8'hD0);
    rd(1'b0, v); chk("R8 aux first", v, 8'hEF);
    rd(1'b0, v); chk("R8 kbd byte", v, 8'hEE);
    rd(1'b0, v); chk("R8 outport flags", v, 8'h31);

    // R2 / R5 flags and interrupts
    wr(1'b1, 8'hD2); wr(1'b0, 8'h10);
    rd(1'b1, v); chk("R2 kbd push status", v, 8'h0D);
    chk("R5 irq after kbd push", {6'd0, irq_kbd, irq_aux}, 8'h02);
    wr(1'b1, 8'hD3); wr(1'b0, 8'h20);
    wr(1'b1, 8'hD3); wr(1'b0, 8'h21);
    rd(1'b1, v); chk("R2 aux push status", v, 8'h2D);
    chk("R5 irq both", {6'd0, irq_kbd, irq_aux}, 8'h03);
    wr(1'b1, 8'h60); wr(1'b0, 8'h00);
    chk("R5 irqs masked", {6'd0, irq_kbd, irq_aux}, 8'h00);
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);

    // R3 / R4 priority and flag clearing
    rd(1'b0, v); chk("R3 aux first", v, 8'h20);
    rd(1'b1, v); chk("R4 aux still holds", v, 8'h2D);
    rd(1'b0, v); chk("R3 aux second", v, 8'h21);
    rd(1'b1, v); chk("R4 aux cleared kbd kept", v, 8'h0D);
    chk("R5 aux irq drops", {6'd0, irq_kbd, irq_aux}, 8'h02);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_sel_cmd = 1'b1; bus_wdata = 8'hA8;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    rd(1'b0, v); chk("R3 read with write ignored", v, 8'h10);
    rd(1'b1, v); chk("R4 all cleared", v, 8'h0C);

    // R10 output port writes
    wr(1'b1, 8'hD1); wr(1'b0, 8'h03);
    chk("R10 gate and no reset", {6'd0, a20_gate, sys_reset_req}, 8'h02);
    wr(1'b1, 8'hD1); wr(1'b0, 8'h00);
    chk("R10 reset pulse", {6'd0, a20_gate, sys_reset_req}, 8'h01);
    @(negedge clk); chk("R11 pulse one cycle", {7'd0, sys_reset_req}, 8'h00);

    // R11 reset command
    wr(1'b1, 8'hFE); chk("R11 reset command", {7'd0, sys_reset_req}, 8'h01);
    @(negedge clk); chk("R11 pulse ends", {7'd0, sys_reset_req}, 8'h00);

    // R13 forwarding
    wr(1'b0, 8'hED);
    chk("R13 valid", {7'd0, kbd_tx_valid}, 8'h01);
    chk("R13 byte", kbd_tx_byte, 8'hED);
    @(negedge clk); chk("R13 one cycle", {7'd0, kbd_tx_valid}, 8'h00);
    rd(1'b1, v); chk("R13 not queued", v, 8'h0C);
    wr(1'b1, 8'hD2); wr(1'b0, 8'h44); wr(1'b0, 8'h45);
    chk("R9 pending cleared forwards", kbd_tx_byte, 8'h45);
    rd(1'b0, v); chk("R9 single byte queued", v, 8'h44);

    // R12 capacity and drop
    for (int i = 0; i < 70; i++) begin
      wr(1'b1, 8'hD2); wr(1'b0, 8'(i));
    end
    for (int i = 0; i < 64; i++) begin
      rd(1'b0, v);
      chk($sformatf("R12 order %0d", i), v, 8'(i));
    end
    rd(1'b0, v); chk("R12 overflow dropped", v, 8'h00);
    rd(1'b1, v); chk("R12 drained status", v, 8'h0C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule